// File: doc/BRIEF.md
# Stored-Setting Recall Sequencer

This block restores twelve 8-bit channel settings from a small non-volatile store into the channel output registers. The store holds four banks of twelve words, one word per channel. A recall copies every word of one bank into the outputs. The copy always runs from channel 1 up to channel 12, and each channel takes a fixed number of system clocks.

A recall starts in one of three ways. The block starts one by itself on the first clock edge after reset. It also starts one on a rising edge of the recall pin, and on an all-channel recall command. The two recalls that do not come from a command read the bank number from the bank pins. The bank is captured when the recall starts and stays fixed until the recall ends. While a recall runs, the block shows `busy` and ignores commands and new recall requests. Every recall also turns programming of the store off. A short command set can turn programming on or off and can write single words into the store. After a recall ends, the block refuses a new pin-triggered recall for a set number of clock edges.

Top module: `recall_seq_top`

## Requirements
- R1: The store holds NUM_BANK (4) banks of NUM_CH (12) words of DATA_W (8) bits. After reset, word c (0-based) of bank b holds (16*b + c) XOR 0xA5.
- R2: While reset is asserted, `busy`, `prog_en` and all channel outputs are 0. On the first clock edge after reset is released, a recall starts from the bank on `bank_pins`, and `busy` is 1 from that edge on.
- R3: A recall starts on a clock edge at which `recall_pin` is 1 and was 0 at the previous edge. The bank comes from `bank_pins` at that edge. Holding the pin high does not start another recall.
- R4: A command with `cmd_cl`=1, `cmd_wr`=0 and `cmd_chan`=4'b0000 starts a recall from the bank in `cmd_bank`.
- R5: A recall that starts at edge E writes channel k (1-based, output bits [8k-1:8k-8]) at edge E+k*STEP_CLKS. `busy` drops at edge E+12*STEP_CLKS. Channel outputs change only at these writes.
- R6: The bank captured at the start of a recall is used for all twelve channels, even if `bank_pins` changes during the recall.
- R7: Any recall sets `prog_en` to 0 at its starting edge, and `prog_en` stays 0 while `busy` is 1.
- R8: A rising edge of `recall_pin` is dropped if it is seen at any of the REPEAT_GAP clock edges that follow the edge at which `busy` dropped. The first edge after that window is accepted. A dropped request is not queued.
- R9: While `busy` is 1, commands and edges on `recall_pin` are ignored and do not start another recall.
- R10: A command with `cmd_cl`=1 and `cmd_wr`=1 sets `prog_en` when `cmd_chan`=4'b0000 and clears it when `cmd_chan`=4'b1111.
- R11: A command with `cmd_cl`=0, `cmd_wr`=1 and `cmd_chan` from 1 to 12 writes `cmd_data` into word `cmd_chan`-1 of bank `cmd_bank`. If `prog_en` is 0, the command is ignored.
- R12: If an accepted pin edge and a command arrive at the same edge, the pin recall wins and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| recall_pin | input | 1 | Recall request; a rising edge starts a recall |
| bank_pins | input | 2 | Bank used by power-up and pin recalls |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_cl | input | 1 | Command recall/control flag |
| cmd_wr | input | 1 | Command write flag |
| cmd_chan | input | 4 | Command channel field |
| cmd_bank | input | 2 | Command bank |
| cmd_data | input | 8 | Command data for a store write |
| busy | output | 1 | A recall is in progress |
| prog_en | output | 1 | Programming of the store is enabled |
| ch_out | output | 96 | Twelve channel registers; channel k at bits [8k-1:8k-8] |

## Verification
The assertions check, on every cycle, the rules that hold at all times:
- Channel writes follow each other in strict ascending order.
- Outputs change only on a write strobe.
- `busy` rises after a start and falls after the last write.
- No recall starts while `busy` is 1.
- `prog_en` stays 0 during a recall.
- The captured bank holds steady during a recall.
- No pin recall is accepted inside the repeat window.

Only the bench scenarios can show the rest: the stored data values, that the right bank is picked for each trigger, the exact edge at which each channel updates, the two sides of the repeat-window boundary, and that dropped commands leave no trace in the store.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RECALL,
    OP_WEN,
    OP_WDIS,
    OP_PROG
  } rcs_op_e;

  // Power-on content of the store (R1): word c of bank b.
  function automatic int nv_default(int bank, int ch);
    return ((bank * 16) + ch) ^ 'hA5;
  endfunction

  // Command field decode (R4, R10, R11).
  function automatic rcs_op_e decode_op(logic cl, logic wr, logic [3:0] chan, int nch);
    if (cl && !wr && chan == 4'h0)                      return OP_RECALL;
    if (cl && wr && chan == 4'h0)                       return OP_WEN;
    if (cl && wr && chan == 4'hF)                       return OP_WDIS;
    if (!cl && wr && chan != 4'h0 && int'(chan) <= nch) return OP_PROG;
    return OP_NONE;
  endfunction

endpackage

// File: rtl/rcs_pin_guard.sv
module rcs_pin_guard #(
  parameter int REPEAT_GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic busy,
  input  logic seq_done,
  output logic pin_edge,
  output logic guard_active,
  output logic pin_accept
);
  localparam int GW = $clog2(REPEAT_GAP + 1);

  logic          pin_q;
  logic [GW-1:0] gap_cnt;

  assign pin_edge     = pin && !pin_q;
  assign guard_active = (gap_cnt != '0);
  assign pin_accept   = pin_edge && !busy && !guard_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b1;
      gap_cnt <= '0;
    end else begin
      pin_q <= pin;
      if (seq_done)
        gap_cnt <= GW'(REPEAT_GAP);
      else if (guard_active)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rcs_nvstore.sv
module rcs_nvstore
  import rcs_pkg::*;
#(
  parameter int NUM_BANK = 4,
  parameter int NUM_CH   = 12,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wbank,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BANK_W-1:0] rbank,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_BANK][NUM_CH];

  assign rdata = mem[rbank][ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANK; b++)
        for (int c = 0; c < NUM_CH; c++)
          mem[b][c] <= DATA_W'(nv_default(b, c));
    end else if (we) begin
      mem[wbank][widx] <= wdata;
    end
  end
endmodule

// File: rtl/rcs_sequencer.sv
module rcs_sequencer #(
  parameter int NUM_CH    = 12,
  parameter int DATA_W    = 8,
  parameter int STEP_CLKS = 2,
  parameter int BANK_W    = 2,
  parameter int IDX_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BANK_W-1:0]        start_bank,
  input  logic [DATA_W-1:0]        rdata,
  output logic [BANK_W-1:0]        rbank,
  output logic [IDX_W-1:0]         ridx,
  output logic                     busy,
  output logic                     ch_wr,
  output logic                     seq_done,
  output logic [NUM_CH*DATA_W-1:0] ch_out
);
  localparam int SW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;

  logic              run;
  logic [IDX_W-1:0]  idx;
  logic [SW-1:0]     step_cnt;
  logic [BANK_W-1:0] bank_q;

  assign busy     = run;
  assign rbank    = bank_q;
  assign ridx     = idx;
  assign ch_wr    = run && (step_cnt == SW'(STEP_CLKS - 1));
  assign seq_done = ch_wr && (idx == IDX_W'(NUM_CH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      idx      <= '0;
      step_cnt <= '0;
      bank_q   <= '0;
    end else if (start) begin
      run      <= 1'b1;
      idx      <= '0;
      step_cnt <= '0;
      bank_q   <= start_bank;
    end else if (run) begin
      if (ch_wr) begin
        step_cnt <= '0;
        if (seq_done) run <= 1'b0;
        else          idx <= idx + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= '0;
      else if (ch_wr && idx == IDX_W'(g))
        val_q <= rdata;
    end
    assign ch_out[g*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/recall_seq_top.sv
module recall_seq_top
  import rcs_pkg::*;
#(
  parameter int NUM_CH       = 12,
  parameter int DATA_W       = 8,
  parameter int NUM_BANK     = 4,
  parameter int STEP_CLKS    = 2,
  parameter int REPEAT_GAP   = 8,
  parameter int CHAN_FIELD_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             recall_pin,
  input  logic [$clog2(NUM_BANK)-1:0]      bank_pins,
  input  logic                             cmd_valid,
  input  logic                             cmd_cl,
  input  logic                             cmd_wr,
  input  logic [CHAN_FIELD_W-1:0]          cmd_chan,
  input  logic [$clog2(NUM_BANK)-1:0]      cmd_bank,
  input  logic [DATA_W-1:0]                cmd_data,
  output logic                             busy,
  output logic                             prog_en,
  output logic [NUM_CH*DATA_W-1:0]         ch_out
);
  localparam int BANK_W = $clog2(NUM_BANK);
  localparam int IDX_W  = CHAN_FIELD_W;

  // Named internal events (used by the checker).
  logic              boot_pend;
  logic              pin_edge, guard_active, pin_accept;
  logic              cmd_ok, cmd_recall, start;
  logic [BANK_W-1:0] start_bank, bank_lat;
  logic [IDX_W-1:0]  ch_wr_idx;
  logic              ch_wr, seq_done, store_we;
  logic [DATA_W-1:0] rd_data;
  rcs_op_e           op;

  assign op         = decode_op(cmd_cl, cmd_wr, cmd_chan, NUM_CH);
  assign cmd_ok     = cmd_valid && !busy && !boot_pend && !pin_accept;
  assign cmd_recall = cmd_ok && (op == OP_RECALL);
  assign start      = boot_pend || pin_accept || cmd_recall;
  assign start_bank = cmd_recall ? cmd_bank : bank_pins;
  assign store_we   = cmd_ok && (op == OP_PROG) && prog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
      prog_en   <= 1'b0;
    end else begin
      boot_pend <= 1'b0;
      if (start)
        prog_en <= 1'b0;
      else if (cmd_ok && op == OP_WEN)
        prog_en <= 1'b1;
      else if (cmd_ok && op == OP_WDIS)
        prog_en <= 1'b0;
    end
  end

  rcs_pin_guard #(.REPEAT_GAP(REPEAT_GAP)) u_guard (
    .clk(clk), .rst_n(rst_n), .pin(recall_pin), .busy(busy),
    .seq_done(seq_done), .pin_edge(pin_edge),
    .guard_active(guard_active), .pin_accept(pin_accept)
  );

  rcs_nvstore #(
    .NUM_BANK(NUM_BANK), .NUM_CH(NUM_CH), .DATA_W(DATA_W),
    .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .wbank(cmd_bank),
    .widx(IDX_W'(cmd_chan - 1'b1)), .wdata(cmd_data),
    .rbank(bank_lat), .ridx(ch_wr_idx), .rdata(rd_data)
  );

  rcs_sequencer #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS),
    .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bank(start_bank),
    .rdata(rd_data), .rbank(bank_lat), .ridx(ch_wr_idx), .busy(busy),
    .ch_wr(ch_wr), .seq_done(seq_done), .ch_out(ch_out)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int NUM_CH     = 12,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 2,
  parameter int IDX_W      = 4,
  parameter int REPEAT_GAP = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     prog_en,
  input logic                     start,
  input logic                     pin_accept,
  input logic                     ch_wr,
  input logic [IDX_W-1:0]         ch_wr_idx,
  input logic                     seq_done,
  input logic [BANK_W-1:0]        bank_lat,
  input logic [NUM_CH*DATA_W-1:0] ch_out
);
  int exp_idx;
  int since_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_idx    <= 0;
      since_done <= REPEAT_GAP;
    end else begin
      if (start)      exp_idx <= 0;
      else if (ch_wr) exp_idx <= exp_idx + 1;
      if (seq_done)                    since_done <= 0;
      else if (since_done < REPEAT_GAP) since_done <= since_done + 1;
    end
  end

  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr |-> (int'(ch_wr_idx) == exp_idx)); // R5
  AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_wr |=> $stable(ch_out)); // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R2
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy); // R5
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R9
  AST_PROT_OFF_IN_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_en); // R7
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bank_lat)); // R6
  AST_REPEAT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pin_accept |-> (since_done >= REPEAT_GAP)); // R8
endmodule

bind recall_seq_top rcs_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .IDX_W(IDX_W), .REPEAT_GAP(REPEAT_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prog_en(prog_en),
  .start(start), .pin_accept(pin_accept), .ch_wr(ch_wr),
  .ch_wr_idx(ch_wr_idx), .seq_done(seq_done), .bank_lat(bank_lat),
  .ch_out(ch_out)
);

// File: tb/tb_recall_seq_top.sv
`timescale 1ns/1ps
module tb_recall_seq_top;
  localparam int NCH = 12;
  localparam int S   = 2;
  localparam int G   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        recall_pin = 1'b0;
  logic [1:0]  bank_pins = 2'd0;
  logic        cmd_valid = 1'b0, cmd_cl = 1'b0, cmd_wr = 1'b0;
  logic [3:0]  cmd_chan = 4'd0;
  logic [1:0]  cmd_bank = 2'd0;
  logic [7:0]  cmd_data = 8'd0;
  logic        busy, prog_en;
  logic [95:0] ch_out;

  int total = 0, bad = 0;
  int mem [4][NCH];
  int old_v [NCH];
  bit finished = 0;

  always #2.5 clk = ~clk;

  recall_seq_top dut (
    .clk(clk), .rst_n(rst_n), .recall_pin(recall_pin), .bank_pins(bank_pins),
    .cmd_valid(cmd_valid), .cmd_cl(cmd_cl), .cmd_wr(cmd_wr), .cmd_chan(cmd_chan),
    .cmd_bank(cmd_bank), .cmd_data(cmd_data), .busy(busy), .prog_en(prog_en),
    .ch_out(ch_out)
  );

  function automatic int chv(int c);
    return int'(ch_out[c*8 +: 8]);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_bank(string req, int b);
    for (int c = 0; c < NCH; c++) check(req, chv(c), mem[b][c]);
  endtask

  task automatic send_cmd(bit cl, bit wr, int chan, int bank, int data);
    cmd_cl = cl; cmd_wr = wr; cmd_chan = 4'(chan); cmd_bank = 2'(bank);
    cmd_data = 8'(data); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic settle_gap();
    repeat (G + 2) @(negedge clk);
  endtask

  task automatic pin_recall(int b);
    bank_pins = 2'(b); recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
    wait_idle();
  endtask

  initial begin
    int cyc;
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < NCH; c++) mem[b][c] = ((b * 16) + c) ^ 165;

    // Reset state and power-up recall
    bank_pins = 2'd2;
    repeat (3) @(negedge clk);
    check("R2 busy in reset", busy, 0);
    check("R2 prog_en in reset", prog_en, 0);
    check("R2 outputs in reset", (ch_out == '0) ? 1 : 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 busy after first edge", busy, 1);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    check("R5 busy length", cyc, NCH * S);
    check_bank("R1 R2 power-up bank", 2);
    check("R2 prog_en after power-up", prog_en, 0);
    settle_gap();

    // Per-cycle order of writes (R5) with a held pin (R3)
    for (int c = 0; c < NCH; c++) old_v[c] = mem[2][c];
    bank_pins = 2'd0; recall_pin = 1'b1;
    @(negedge clk);
    for (int j = 0; j <= NCH * S; j++) begin
      for (int c = 0; c < NCH; c++)
        check("R5 channel timing", chv(c), ((c + 1) * S <= j) ? mem[0][c] : old_v[c]);
      check("R5 busy timing", busy, (j < NCH * S) ? 1 : 0);
      @(negedge clk);
    end
    repeat (3 * G) @(negedge clk);
    check("R3 held pin no retrigger", busy, 0);
    recall_pin = 1'b0;
    settle_gap();

    // Sweep of banks by command (R4) and by pin (R3), R1 contents
    for (int b = 0; b < 4; b++) begin
      send_cmd(1, 0, 0, b, 0);
      check("R4 cmd recall busy", busy, 1);
      wait_idle();
      check_bank("R4 R1 cmd recall bank", b);
    end
    for (int b = 3; b >= 0; b--) begin
      settle_gap();
      pin_recall(b);
      check_bank("R3 R1 pin recall bank", b);
    end

    // Bank latched at start (R6)
    settle_gap();
    bank_pins = 2'd1; recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
    repeat (3) @(negedge clk);
    bank_pins = 2'd3;
    wait_idle();
    check_bank("R6 bank held", 1);

    // Program while disabled is ignored (R11)
    send_cmd(0, 1, 5, 3, 8'h11);
    send_cmd(1, 0, 0, 3, 0);
    wait_idle();
    check_bank("R11 write ignored when disabled", 3);

    // Enable, program all words, verify (R10, R11)
    send_cmd(1, 1, 0, 0, 0);
    check("R10 enable", prog_en, 1);
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < NCH; c++) begin
        int d;
        d = (b * 37 + c * 11 + 3) % 256;
        send_cmd(0, 1, c + 1, b, d);
        mem[b][c] = d;
      end
    check("R11 prog_en kept by writes", prog_en, 1);
    send_cmd(1, 0, 0, 2, 0);
    check("R7 cmd recall clears prog_en", prog_en, 0);
    wait_idle();
    check_bank("R11 programmed bank 2", 2);
    for (int b = 0; b < 4; b++) begin
      send_cmd(1, 0, 0, b, 0);
      wait_idle();
      check_bank("R11 programmed sweep", b);
    end
    send_cmd(1, 1, 0, 0, 0);
    send_cmd(1, 1, 15, 0, 0);
    check("R10 disable", prog_en, 0);
    send_cmd(1, 1, 0, 0, 0);
    settle_gap();
    bank_pins = 2'd1; recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
    check("R7 pin recall clears prog_en", prog_en, 0);
    wait_idle();

    // Requests during busy ignored (R9)
    send_cmd(1, 0, 0, 0, 0);
    @(negedge clk);
    send_cmd(1, 0, 0, 3, 0);
    send_cmd(1, 1, 0, 0, 0);
    bank_pins = 2'd2; recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
    check("R9 enable during busy", prog_en, 0);
    wait_idle();
    @(negedge clk);
    check("R9 no second recall", busy, 0);
    check_bank("R9 outputs from first bank", 0);

    // Repeat window boundary (R8)
    settle_gap();
    pin_recall(1);
    repeat (G - 1) @(negedge clk);
    bank_pins = 2'd3; recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
    check("R8 edge inside window dropped", busy, 0);
    repeat (2) @(negedge clk);
    check("R8 dropped not queued", busy, 0);
    settle_gap();
    pin_recall(2);
    repeat (G) @(negedge clk);
    bank_pins = 2'd3; recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
    check("R8 edge after window accepted", busy, 1);
    wait_idle();
    check_bank("R8 accepted bank", 3);

    // Pin and command together: pin wins (R12)
    send_cmd(1, 1, 0, 0, 0);
    settle_gap();
    bank_pins = 2'd1; recall_pin = 1'b1;
    send_cmd(0, 1, 1, 1, 8'h3C);
    recall_pin = 1'b0;
    check("R12 pin recall started", busy, 1);
    wait_idle();
    check_bank("R12 command dropped", 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule